// File: doc/BRIEF.md
# Descriptor-Chain DMA Command Sequencer

This block is a single-channel command engine. It walks a linked list of 16-byte descriptors held in memory. A control unit loads the starting descriptor address and raises `run_i`. From then on the sequencer works on its own: it reads each descriptor through a word-wide memory port and decodes it. It then does one of four things: hands a buffer transfer to a device-side data mover, moves a small word between memory and the descriptor, does nothing (NOP), or halts (STOP).

Every command carries three 2-bit condition modes: wait, interrupt and branch. Each mode is tested against four device-status bits through its own mask/value selector. When a command completes, the sequencer does three things:

1. It stores a status snapshot and the residual count back into the descriptor.
2. It optionally pulses the interrupt.
3. It either steps to the next descriptor, 16 bytes further on, or jumps to the address held in the descriptor's dependent word.

An illegal descriptor kills the channel. The channel is marked dead, goes inactive and raises an interrupt.

Top module: `desc_chain_seq`

## Requirements
- R1: While active and `run_i` is high and the sequencer is idle, it reads the descriptor as three 32-bit words, at pointer, pointer+4 and pointer+8. The words are little-endian: word0 holds the request count in [15:0] and the command in [31:16], word1 holds the data address, and word2 holds the dependent word. The memory request holds its address and write flag until acknowledged.
- R2: The command fields are: opcode in [15:12], key in [10:8], interrupt mode in [5:4], branch mode in [3:2] and wait mode in [1:0]. Opcodes 0 to 3 (output-more, output-last, input-more, input-last) raise `xfer_req_o` until `xfer_done_i`. The transfer uses the descriptor's address and request count, with `xfer_out_o`=1 for opcodes 0 and 1 and `xfer_last_o`=1 for opcodes 1 and 3.
- R3: The channel is killed in any of these cases:
  - key 4;
  - an opcode above 7;
  - a transfer whose address is zero or whose key is above 3;
  - a load-word or store-word whose key is not 6.

  A kill sets `dead_o`, clears `active_o`, gives one `irq_o` pulse and writes nothing back.
- R4: A condition is true when (dev_stat & mask) == (value & mask). Each selector input is {mask[7:4], value[3:0]}. The modes are 0 never, 1 if the condition is true, 2 if it is false, and 3 always.
- R5: After the command's action, the sequencer stalls while the wait mode fires. It writes nothing to the descriptor until the wait mode stops firing.
- R6: Completion writes the word at pointer+12. Bits [15:0] hold the residual: `xfer_resid_i` for transfers, 0 otherwise. Bits [31:16] hold the status: bit15 run, bit13 flush, bit12 wake, bit11 dead, bit10 active, bit8 branch-taken, bits 3:0 device status, other bits 0.
- R7: After the write-back, one `irq_o` pulse is given if the interrupt mode fires.
- R8: If the branch mode fires, the pointer becomes the dependent word with bits [3:0] cleared and `bt_o` is set. Otherwise the pointer advances by 16 and `bt_o` clears. Load-word and store-word never branch.
- R9: Load-word takes its size from request-count bits [2:0]: bit2 selects 4 bytes, else bit1 selects 2 bytes, else 1 byte. It reads the size-aligned bytes at the data address. The dependent word becomes the value read (4 bytes), {value, dep[15:0]} (2 bytes) or {value, dep[23:0]} (1 byte). The new dependent word is written to pointer+8 before the status write.
- R10: Store-word writes dep (4 bytes), dep[31:16] (2 bytes) or dep[31:24] (1 byte) to the data address, using only the byte lanes of that size.
- R11: STOP clears active, dead and flush. It leaves the pointer unchanged, writes nothing back and raises no interrupt.
- R12: The wake flag (set by `wake_i`) is cleared at each descriptor fetch. The flush flag (set by `flush_i`) is cleared after each status write-back.
- R13: `start_i` loads the pointer from `start_line_i`×16, sets active and clears dead and branch-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Load pointer and activate |
| start_line_i | input | 28 | First descriptor address divided by 16 |
| run_i | input | 1 | Permission to fetch descriptors |
| wake_i | input | 1 | Sets the wake flag |
| flush_i | input | 1 | Sets the flush flag |
| dev_stat_i | input | 4 | Device status bits |
| wait_sel_i | input | 8 | Wait selector {mask, value} |
| intr_sel_i | input | 8 | Interrupt selector {mask, value} |
| br_sel_i | input | 8 | Branch selector {mask, value} |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| xfer_req_o | output | 1 | Data transfer request |
| xfer_addr_o | output | 32 | Transfer buffer address |
| xfer_len_o | output | 16 | Transfer byte count |
| xfer_out_o | output | 1 | 1 = memory to device |
| xfer_last_o | output | 1 | Last transfer of a packet |
| xfer_done_i | input | 1 | Transfer complete |
| xfer_resid_i | input | 16 | Bytes not transferred |
| irq_o | output | 1 | Interrupt pulse |
| active_o | output | 1 | Channel active |
| dead_o | output | 1 | Channel killed |
| bt_o | output | 1 | Last advance was a branch |
| cmd_ptr_o | output | 32 | Current descriptor address |

## Verification
The sequencer's internal state reaches memory only a few cycles after it goes wrong. A wrong branch-taken, wake or flush flag shows up in the status half of the next write-back word, and the same goes for a stale device status. A mis-merged dependent word is visible at pointer+8 as soon as that load-word completes. A wrong pointer step makes the next descriptor read go to the wrong address. That in turn makes the final `cmd_ptr_o` and the following write-back locations disagree with the expected chain within one descriptor. A misjudged kill or stop shows at once as `dead_o`/`active_o` and an interrupt count off by one, before any memory write happens.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int HALF_W     = 16;
  localparam int DEV_W      = 4;
  localparam int SEL_W      = 2 * DEV_W;
  localparam int DESC_BYTES = 16;
  localparam int LINE_W     = ADDR_W - 4;
  localparam int BE_W       = WORD_W / 8;

  localparam logic [3:0] OP_OUT_MORE = 4'd0;
  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_IN_MORE  = 4'd2;
  localparam logic [3:0] OP_IN_LAST  = 4'd3;
  localparam logic [3:0] OP_STORE    = 4'd4;
  localparam logic [3:0] OP_LOAD     = 4'd5;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;

  localparam logic [2:0] KEY_STREAM_MAX = 3'd3;
  localparam logic [2:0] KEY_ILLEGAL    = 3'd4;
  localparam logic [2:0] KEY_SYSTEM     = 3'd6;

  typedef enum logic [1:0] {
    MODE_NEVER  = 2'd0,
    MODE_IFSET  = 2'd1,
    MODE_IFCLR  = 2'd2,
    MODE_ALWAYS = 2'd3
  } mode_e;

  // masked comparison of device status against a {mask, value} selector
  function automatic logic sel_match(input logic [SEL_W-1:0] sel,
                                     input logic [DEV_W-1:0] st);
    logic [DEV_W-1:0] m;
    m = sel[SEL_W-1:DEV_W];
    return (st & m) == (sel[DEV_W-1:0] & m);
  endfunction

  function automatic logic mode_fires(input logic [1:0] mode, input logic c);
    case (mode_e'(mode))
      MODE_NEVER:  return 1'b0;
      MODE_IFSET:  return c;
      MODE_IFCLR:  return !c;
      default:     return 1'b1;
    endcase
  endfunction

  // size code priority: bit2 -> 4 bytes, bit1 -> 2 bytes, else 1 byte
  function automatic logic [2:0] lane_bytes(input logic [2:0] sz);
    if (sz[2])      return 3'd4;
    else if (sz[1]) return 3'd2;
    else            return 3'd1;
  endfunction

  function automatic logic [HALF_W-1:0] pack_status(
      input logic run, input logic flush, input logic wake, input logic dead,
      input logic active, input logic bt, input logic [DEV_W-1:0] dev);
    return {run, 1'b0, flush, wake, dead, active, 1'b0, bt, 4'b0000, dev};
  endfunction
endpackage

// File: rtl/dcs_cond_bank.sv
module dcs_cond_bank
  import dcs_pkg::*;
#(
  parameter int NCOND = 3
) (
  input  logic [NCOND*SEL_W-1:0] sel_flat,
  input  logic [NCOND*2-1:0]     mode_flat,
  input  logic [DEV_W-1:0]       dev_stat,
  output logic [NCOND-1:0]       fire
);
  for (genvar g = 0; g < NCOND; g++) begin : g_cond
    logic hit;
    assign hit     = sel_match(sel_flat[g*SEL_W +: SEL_W], dev_stat);
    assign fire[g] = mode_fires(mode_flat[g*2 +: 2], hit);
  end
endmodule

// File: rtl/dcs_word_lane.sv
module dcs_word_lane
  import dcs_pkg::*;
(
  input  logic [1:0]        byte_off,
  input  logic [2:0]        size_code,
  input  logic [WORD_W-1:0] dep,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] wdata,
  output logic [BE_W-1:0]   be
);
  logic [2:0]        nb;
  logic [4:0]        sh;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] src;
  logic [BE_W-1:0]   lanes;

  always_comb begin
    nb  = lane_bytes(size_code);
    sh  = {byte_off, 3'b000};
    raw = rdata >> sh;
    case (nb)
      3'd4: begin
        merged = raw;
        src    = dep;
        lanes  = 4'hF;
      end
      3'd2: begin
        merged = {raw[15:0], dep[15:0]};
        src    = {16'h0, dep[31:16]};
        lanes  = 4'h3;
      end
      default: begin
        merged = {raw[7:0], dep[23:0]};
        src    = {24'h0, dep[31:24]};
        lanes  = 4'h1;
      end
    endcase
    wdata = src << sh;
    be    = lanes << byte_off;
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic              run_i,
  input  logic              wake_i,
  input  logic              flush_i,
  input  logic [DEV_W-1:0]  dev_stat_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  input  logic [SEL_W-1:0]  intr_sel_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [BE_W-1:0]   mem_be_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              xfer_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [HALF_W-1:0] xfer_len_o,
  output logic              xfer_out_o,
  output logic              xfer_last_o,
  input  logic              xfer_done_i,
  input  logic [HALF_W-1:0] xfer_resid_i,
  output logic              irq_o,
  output logic              active_o,
  output logic              dead_o,
  output logic              bt_o,
  output logic [ADDR_W-1:0] cmd_ptr_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XFER, S_LDST, S_WAIT, S_WBDEP, S_WBST, S_POST
  } state_e;

  localparam int NCOND  = 3;
  localparam int C_WAIT = 0;
  localparam int C_INTR = 1;
  localparam int C_BR   = 2;

  state_e            state;
  logic [1:0]        fidx;
  logic [ADDR_W-1:0] ptr;
  logic [HALF_W-1:0] req_cnt;
  logic [3:0]        op;
  logic [2:0]        key;
  logic [1:0]        m_wait, m_intr, m_br;
  logic [ADDR_W-1:0] daddr;
  logic [WORD_W-1:0] dep;
  logic [HALF_W-1:0] resid;
  logic              active, dead, bt, wake, flush, irq;

  // named internal events
  logic [NCOND-1:0]  fire;
  logic              wait_fire, intr_fire, br_fire;
  logic              is_xfer, is_ldst, kill, take_branch;
  logic [WORD_W-1:0] ld_merged, st_wdata;
  logic [BE_W-1:0]   st_be;

  dcs_cond_bank #(.NCOND(NCOND)) u_cond (
    .sel_flat  ({br_sel_i, intr_sel_i, wait_sel_i}),
    .mode_flat ({m_br, m_intr, m_wait}),
    .dev_stat  (dev_stat_i),
    .fire      (fire)
  );

  dcs_word_lane u_lane (
    .byte_off  (daddr[1:0]),
    .size_code (req_cnt[2:0]),
    .dep       (dep),
    .rdata     (mem_rdata_i),
    .merged    (ld_merged),
    .wdata     (st_wdata),
    .be        (st_be)
  );

  assign wait_fire   = fire[C_WAIT];
  assign intr_fire   = fire[C_INTR];
  assign br_fire     = fire[C_BR];
  assign is_xfer     = (op <= OP_IN_LAST);
  assign is_ldst     = (op == OP_STORE) || (op == OP_LOAD);
  assign kill        = (key == KEY_ILLEGAL) || (op > OP_STOP) ||
                       (is_xfer && ((daddr == '0) || (key > KEY_STREAM_MAX))) ||
                       (is_ldst && (key != KEY_SYSTEM));
  assign take_branch = (state == S_POST) && !is_ldst && br_fire;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_wdata_o = '0;
    mem_be_o    = '1;
    case (state)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr + {28'h0, fidx, 2'b00};
      end
      S_LDST: begin
        mem_req_o   = 1'b1;
        mem_we_o    = (op == OP_STORE);
        mem_addr_o  = {daddr[ADDR_W-1:2], 2'b00};
        mem_wdata_o = st_wdata;
        mem_be_o    = st_be;
      end
      S_WBDEP: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + 32'd8;
        mem_wdata_o = dep;
      end
      S_WBST: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + 32'd12;
        mem_wdata_o = {pack_status(run_i, flush, wake, dead, active, bt, dev_stat_i), resid};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      fidx    <= '0;
      ptr     <= '0;
      req_cnt <= '0;
      op      <= OP_NOP;
      key     <= '0;
      m_wait  <= '0;
      m_intr  <= '0;
      m_br    <= '0;
      daddr   <= '0;
      dep     <= '0;
      resid   <= '0;
      active  <= 1'b0;
      dead    <= 1'b0;
      bt      <= 1'b0;
      wake    <= 1'b0;
      flush   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wake_i)  wake  <= 1'b1;
      if (flush_i) flush <= 1'b1;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            ptr    <= {start_line_i, 4'b0000};
            active <= 1'b1;
            dead   <= 1'b0;
            bt     <= 1'b0;
          end else if (active && run_i) begin
            state <= S_FETCH;
            fidx  <= '0;
            wake  <= 1'b0;
          end
        end
        S_FETCH: begin
          if (mem_ack_i) begin
            case (fidx)
              2'd0: begin
                req_cnt <= mem_rdata_i[15:0];
                op      <= mem_rdata_i[31:28];
                key     <= mem_rdata_i[26:24];
                m_intr  <= mem_rdata_i[21:20];
                m_br    <= mem_rdata_i[19:18];
                m_wait  <= mem_rdata_i[17:16];
              end
              2'd1:    daddr <= mem_rdata_i;
              default: dep   <= mem_rdata_i;
            endcase
            if (fidx == 2'd2) state <= S_DECODE;
            else              fidx  <= fidx + 2'd1;
          end
        end
        S_DECODE: begin
          resid <= '0;
          if (kill) begin
            dead   <= 1'b1;
            active <= 1'b0;
            irq    <= 1'b1;
            state  <= S_IDLE;
          end else if (is_xfer) begin
            state <= S_XFER;
          end else if (is_ldst) begin
            state <= S_LDST;
          end else if (op == OP_NOP) begin
            state <= S_WAIT;
          end else begin
            active <= 1'b0;
            dead   <= 1'b0;
            flush  <= 1'b0;
            state  <= S_IDLE;
          end
        end
        S_XFER: begin
          if (xfer_done_i) begin
            resid <= xfer_resid_i;
            state <= S_WAIT;
          end
        end
        S_LDST: begin
          if (mem_ack_i) begin
            if (op == OP_LOAD) dep <= ld_merged;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!wait_fire) state <= (op == OP_LOAD) ? S_WBDEP : S_WBST;
        end
        S_WBDEP: begin
          if (mem_ack_i) state <= S_WBST;
        end
        S_WBST: begin
          if (mem_ack_i) begin
            flush <= 1'b0;
            state <= S_POST;
          end
        end
        S_POST: begin
          irq <= intr_fire;
          if (take_branch) begin
            ptr <= {dep[ADDR_W-1:4], 4'b0000};
            bt  <= 1'b1;
          end else begin
            ptr <= ptr + DESC_BYTES;
            bt  <= 1'b0;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign xfer_req_o  = (state == S_XFER);
  assign xfer_addr_o = daddr;
  assign xfer_len_o  = req_cnt;
  assign xfer_out_o  = (op == OP_OUT_MORE) || (op == OP_OUT_LAST);
  assign xfer_last_o = (op == OP_OUT_LAST) || (op == OP_IN_LAST);
  assign irq_o       = irq;
  assign active_o    = active;
  assign dead_o      = dead;
  assign bt_o        = bt;
  assign cmd_ptr_o   = ptr;

  // R1: an unacknowledged memory request keeps its address and direction
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R2: a transfer never overlaps a memory access and only runs while active
  a_r2_xfer_excl: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> !mem_req_o && active_o);

  // R3: a killed channel is never active
  a_r3_dead_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dead_o |-> !active_o);

  // R5: while the wait condition fires nothing is written
  a_r5_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) && wait_fire |=> !mem_req_o);

  // R7: the interrupt is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R8: a sequential step adds one descriptor length and clears branch-taken
  a_r8_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POST) && !take_branch |=> (cmd_ptr_o == $past(cmd_ptr_o) + 32'd16) && !bt_o);

  // R11: STOP deactivates without moving the pointer
  a_r11_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE) && !kill && (op == OP_STOP) |=> !active_o && $stable(cmd_ptr_o));
endmodule

// File: tb/tb_desc_chain_seq.sv
module tb_desc_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [27:0] start_line_i = '0;
  logic        run_i = 1'b0;
  logic        wake_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [3:0]  dev_stat_i = '0;
  logic [7:0]  wait_sel_i = '0;
  logic [7:0]  intr_sel_i = '0;
  logic [7:0]  br_sel_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        xfer_req_o;
  logic [31:0] xfer_addr_o;
  logic [15:0] xfer_len_o;
  logic        xfer_out_o, xfer_last_o;
  logic        xfer_done_i = 1'b0;
  logic [15:0] xfer_resid_i = '0;
  logic        irq_o, active_o, dead_o, bt_o;
  logic [31:0] cmd_ptr_o;

  always #5 clk = ~clk;

  desc_chain_seq dut (.*);

  int checks = 0;
  int errors = 0;
  int irq_total = 0;
  logic [31:0] mem [0:255];
  logic [31:0] cap_addr;
  logic [15:0] cap_len;
  logic        cap_out, cap_last;

  // memory: one-cycle acknowledge, byte-enabled writes
  always @(posedge clk) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i <= 1'b1;
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) mem[mem_addr_o[9:2]][b*8 +: 8] = mem_wdata_o[b*8 +: 8];
      end else begin
        mem_rdata_i <= mem[mem_addr_o[9:2]];
      end
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  // device: completes a transfer one cycle after the request
  always @(posedge clk) begin
    xfer_done_i <= xfer_req_o && !xfer_done_i;
    if (xfer_req_o && !xfer_done_i) begin
      cap_addr <= xfer_addr_o;
      cap_len  <= xfer_len_o;
      cap_out  <= xfer_out_o;
      cap_last <= xfer_last_o;
    end
  end

  always @(posedge clk) if (rst_n && irq_o) irq_total = irq_total + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cmdw(input logic [3:0] op, input logic [2:0] key,
      input logic [1:0] intr, input logic [1:0] br, input logic [1:0] wt);
    return {op, 1'b0, key, 2'b00, intr, br, wt};
  endfunction

  task automatic put_desc(input logic [31:0] p, input logic [15:0] req,
      input logic [15:0] cmd, input logic [31:0] addr, input logic [31:0] dep);
    mem[p[9:2]]     = {cmd, req};
    mem[p[9:2] + 1] = addr;
    mem[p[9:2] + 2] = dep;
    mem[p[9:2] + 3] = 32'hDEAD_BEEF;
  endtask

  task automatic go(input logic [31:0] p);
    @(negedge clk);
    start_line_i = p[31:4];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_inactive(input string tag);
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!active_o) begin ok = 1; break; end
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=active expected=inactive", tag);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R13 reset active", {31'b0, active_o}, 32'd0);
    chk("R3 reset dead", {31'b0, dead_o}, 32'd0);
    chk("R7 reset irq", {31'b0, irq_o}, 32'd0);
    chk("R1 reset mem_req", {31'b0, mem_req_o}, 32'd0);
    chk("R13 reset ptr", cmd_ptr_o, 32'd0);
  endtask

  task automatic t_out_last;
    int i0;
    put_desc(32'h100, 16'h0040, cmdw(4'd1, 3'd0, 2'd3, 2'd0, 2'd0), 32'h2000, 32'h0);
    put_desc(32'h110, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    xfer_resid_i = 16'h0005;
    i0 = irq_total;
    go(32'h100);
    wait_inactive("R2 out-last chain");
    chk("R2 xfer addr", cap_addr, 32'h2000);
    chk("R2 xfer len", {16'h0, cap_len}, 32'h40);
    chk("R2 xfer dir out", {31'b0, cap_out}, 32'd1);
    chk("R2 xfer last", {31'b0, cap_last}, 32'd1);
    chk("R6 writeback status/resid", mem[8'h43], 32'h8400_0005);
    chk("R7 always-interrupt count", irq_total - i0, 32'd1);
    chk("R11 stop ptr", cmd_ptr_o, 32'h110);
    chk("R11 stop no writeback", mem[8'h47], 32'hDEAD_BEEF);
    chk("R8 bt after step", {31'b0, bt_o}, 32'd0);
  endtask

  task automatic t_in_branch;
    put_desc(32'h100, 16'h0010, cmdw(4'd2, 3'd0, 2'd0, 2'd3, 2'd0), 32'h2400, 32'h0000_0207);
    put_desc(32'h200, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    xfer_resid_i = 16'h0003;
    go(32'h100);
    wait_inactive("R8 branch chain");
    chk("R2 input dir", {31'b0, cap_out}, 32'd0);
    chk("R2 input-more last", {31'b0, cap_last}, 32'd0);
    chk("R6 input writeback", mem[8'h43], 32'h8400_0003);
    chk("R8 branch target", cmd_ptr_o, 32'h200);
    chk("R8 bt after branch", {31'b0, bt_o}, 32'd1);
  endtask

  task automatic t_cond_branch;
    br_sel_i = 8'h11;
    dev_stat_i = 4'h1;
    put_desc(32'h100, 16'h0, cmdw(4'd6, 3'd0, 2'd0, 2'd1, 2'd0), 32'h0, 32'h180);
    put_desc(32'h180, 16'h0, cmdw(4'd6, 3'd0, 2'd0, 2'd2, 2'd0), 32'h0, 32'h300);
    put_desc(32'h190, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    go(32'h100);
    wait_inactive("R4 cond branch chain");
    chk("R4 if-set branch then if-clear step", cmd_ptr_o, 32'h190);
    chk("R6 status carries bt and devstat", mem[8'h63], 32'h8501_0000);
    chk("R8 bt cleared by step", {31'b0, bt_o}, 32'd0);
    br_sel_i = 8'h00;
    dev_stat_i = 4'h0;
  endtask

  task automatic t_kill_one(input string tag, input logic [15:0] cmd, input logic [31:0] addr);
    int i0;
    put_desc(32'h100, 16'h0004, cmd, addr, 32'h0);
    i0 = irq_total;
    go(32'h100);
    wait_inactive(tag);
    chk({tag, " dead"}, {31'b0, dead_o}, 32'd1);
    chk({tag, " irq"}, irq_total - i0, 32'd1);
    chk({tag, " no writeback"}, mem[8'h43], 32'hDEAD_BEEF);
  endtask

  task automatic t_kill;
    t_kill_one("R3 key4", cmdw(4'd1, 3'd4, 2'd0, 2'd0, 2'd0), 32'h2000);
    t_kill_one("R3 zero addr", cmdw(4'd2, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0);
    t_kill_one("R3 ldst key", cmdw(4'd5, 3'd0, 2'd0, 2'd0, 2'd0), 32'h300);
    t_kill_one("R3 opcode9", cmdw(4'd9, 3'd0, 2'd0, 2'd0, 2'd0), 32'h300);
    put_desc(32'h100, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    go(32'h100);
    wait_inactive("R13 restart");
    chk("R13 start clears dead", {31'b0, dead_o}, 32'd0);
  endtask

  task automatic t_wait;
    wait_sel_i = 8'h22;
    dev_stat_i = 4'h2;
    put_desc(32'h100, 16'h0, cmdw(4'd6, 3'd0, 2'd0, 2'd0, 2'd1), 32'h0, 32'h0);
    put_desc(32'h110, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    go(32'h100);
    repeat (30) @(negedge clk);
    chk("R5 stalled no writeback", mem[8'h43], 32'hDEAD_BEEF);
    chk("R5 stalled still active", {31'b0, active_o}, 32'd1);
    chk("R5 stalled ptr", cmd_ptr_o, 32'h100);
    dev_stat_i = 4'h0;
    wait_inactive("R5 wait release");
    chk("R5 writeback after release", mem[8'h43], 32'h8400_0000);
    wait_sel_i = 8'h00;
  endtask

  task automatic t_intr_modes;
    int i0;
    intr_sel_i = 8'h11;
    put_desc(32'h100, 16'h0, cmdw(4'd6, 3'd0, 2'd2, 2'd0, 2'd0), 32'h0, 32'h0);
    put_desc(32'h110, 16'h0, cmdw(4'd6, 3'd0, 2'd1, 2'd0, 2'd0), 32'h0, 32'h0);
    put_desc(32'h120, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    i0 = irq_total;
    go(32'h100);
    wait_inactive("R7 intr chain");
    chk("R7 if-clear fires, if-set not", irq_total - i0, 32'd1);
    intr_sel_i = 8'h00;
  endtask

  task automatic t_load;
    mem[8'hC0] = 32'hAABB_CCDD;
    put_desc(32'h100, 16'h0003, cmdw(4'd5, 3'd6, 2'd0, 2'd0, 2'd0), 32'h302, 32'h1111_2222);
    put_desc(32'h110, 16'h0001, cmdw(4'd5, 3'd6, 2'd0, 2'd0, 2'd0), 32'h301, 32'h1111_2222);
    put_desc(32'h120, 16'h0007, cmdw(4'd5, 3'd6, 2'd0, 2'd3, 2'd0), 32'h300, 32'h1111_2222);
    put_desc(32'h130, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    go(32'h100);
    wait_inactive("R9 load chain");
    chk("R9 load 2 bytes merge", mem[8'h42], 32'hAABB_2222);
    chk("R9 load 1 byte merge", mem[8'h46], 32'hCC11_2222);
    chk("R9 load 4 bytes", mem[8'h4A], 32'hAABB_CCDD);
    chk("R9 load status written", mem[8'h43], 32'h8400_0000);
    chk("R8 load never branches", cmd_ptr_o, 32'h130);
  endtask

  task automatic t_store;
    mem[8'hD0] = 32'h0;
    mem[8'hD1] = 32'h0;
    mem[8'hD2] = 32'h0;
    put_desc(32'h100, 16'h0001, cmdw(4'd4, 3'd6, 2'd0, 2'd0, 2'd0), 32'h341, 32'h1234_5678);
    put_desc(32'h110, 16'h0002, cmdw(4'd4, 3'd6, 2'd0, 2'd0, 2'd0), 32'h346, 32'h1234_5678);
    put_desc(32'h120, 16'h0004, cmdw(4'd4, 3'd6, 2'd0, 2'd0, 2'd0), 32'h348, 32'h1234_5678);
    put_desc(32'h130, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    go(32'h100);
    wait_inactive("R10 store chain");
    chk("R10 store 1 byte lane1", mem[8'hD0], 32'h0000_1200);
    chk("R10 store 2 bytes upper half", mem[8'hD1], 32'h1234_0000);
    chk("R10 store 4 bytes", mem[8'hD2], 32'h1234_5678);
  endtask

  task automatic t_flags;
    put_desc(32'h100, 16'h0, cmdw(4'd6, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    put_desc(32'h110, 16'h0, cmdw(4'd6, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    put_desc(32'h120, 16'h0, cmdw(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'h0, 32'h0);
    @(negedge clk);
    wake_i = 1'b1;
    flush_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    flush_i = 1'b0;
    go(32'h100);
    wait_inactive("R12 flag chain");
    chk("R12 wake cleared, flush reported", mem[8'h43], 32'hA400_0000);
    chk("R12 flush cleared after writeback", mem[8'h47], 32'h8400_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_i = 1'b1;
    repeat (2) @(negedge clk);
    t_out_last();
    t_in_branch();
    t_cond_branch();
    t_kill();
    t_wait();
    t_intr_modes();
    t_load();
    t_store();
    t_flags();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule